// File: doc/BRIEF.md
# Receive Interrupt Flag Controller

This block keeps the receive-side status flags of a serial channel and raises three interrupt request lines from them: one for received data, one for receive errors and one for break or overrun. The receiver hands it one-cycle set pulses for five events. These are the FIFO fill level reaching its threshold, a data-ready timeout, a framing or parity error, a line break and an overrun. Software observes the flags through a status read port and clears them through a status write port.

A flag can only be cleared by software in two steps. Software must first read the status while that flag is 1. Only then does a write of 0 to that bit take effect. A hardware set that lands in the same cycle as the clear overrides the clear. Software can also withdraw a request without touching the flags, by clearing the enables in a small control register.

The same control register holds the transmit and receive enables. The block watches how those enables are raised. It records a sticky sequencing fault when an enable goes high without a FIFO reset of its own direction since that enable was last raised.

Top module: `rxif_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every flag, enable, the fault bit and all three request lines are 0.
- R2: A set pulse on `flag_set` bit i makes status bit i read 1 from the next cycle. The bit positions are 0 threshold, 1 timeout, 2 error, 3 break and 4 overrun.
- R3: A status read arms every flag that reads 1 in that cycle. A later status write with 0 in an armed flag's bit clears that flag from the next cycle.
- R4: A write of 0 to a flag that is not armed leaves it unchanged. A write of 1 never changes a flag.
- R5: When a set pulse and an armed clear reach the same flag in one cycle, the flag stays 1.
- R6: `irq_rxd` is 1 exactly when the receive interrupt enable is 1 and the threshold or timeout flag is 1.
- R7: `irq_err` equals the error flag ANDed with (receive enable OR error enable). `irq_brk` equals (break OR overrun) ANDed with the same OR of the enables.
- R8: A pulse on `ctl_wr` loads all four control bits from `ctl_wdata`. The bit positions are 0 receive interrupt enable, 1 error interrupt enable, 2 transmit enable and 3 receive enable.
- R9: Status bit 5 becomes 1 when `ctl_wr` raises the transmit enable with no `tx_fifo_rst` pulse since reset or since its last rise, or raises the receive enable with no `rx_fifo_rst` pulse in the same sense. A reset pulse in the same cycle as the write counts as prior.
- R10: Once set, status bit 5 stays 1 until `rst`. Status writes do not affect it.
- R11: Any status write with 0 in a flag's bit disarms that flag, whether or not it cleared. A read while a flag is 0 does not arm it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_set | input | 5 | One-cycle set pulses from the receiver, one per flag |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 5 | Status write data, 0 requests a clear |
| stat_rdata | output | 6 | Flags in bits 4..0, sequencing fault in bit 5 |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write data |
| tx_fifo_rst | input | 1 | Transmit FIFO reset pulse |
| rx_fifo_rst | input | 1 | Receive FIFO reset pulse |
| irq_rxd | output | 1 | Receive-data interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |
| irq_brk | output | 1 | Break/overrun interrupt request |

## Verification
The bench writes 0 to flags that were never armed and writes 1 to set flags. A design that cleared on a bare write would lose those flags. It also sets a flag and clears it in the same cycle, which catches a design where the clear wins. It confirms that a write disarms a flag even when the write had no effect, so a stale arm cannot clear a later event. It also drops one enable at a time to show that the error and break lines follow the OR of the two enables. For sequencing, it shows that a matching FIFO reset lets an enable rise cleanly, and that a reset pulse in the same cycle counts. It shows that the permission is used up on each rise, that the fault survives status writes, and that only reset clears it.

// File: rtl/rxif_pkg.sv
package rxif_pkg;

    localparam int FLAG_N  = 5;
    localparam int STAT_W  = FLAG_N + 1;
    localparam int CTL_W   = 4;
    localparam int LANE_N  = 2;

    localparam int FL_THR  = 0;
    localparam int FL_DRY  = 1;
    localparam int FL_ERR  = 2;
    localparam int FL_BRK  = 3;
    localparam int FL_OVR  = 4;
    localparam int ST_SEQ  = FLAG_N;

    localparam int LN_TX   = 0;
    localparam int LN_RX   = 1;

    typedef struct packed {
        logic re;
        logic te;
        logic reie;
        logic rie;
    } ctl_t;

    typedef struct packed {
        logic rxd;
        logic err;
        logic brk;
    } irq_t;

    function automatic logic any_rx_en(ctl_t c);
        return c.rie | c.reie;
    endfunction

endpackage

// File: rtl/rxif_flag_cell.sv
module rxif_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic rd_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;
    logic arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            flag_q <= set_i | (flag_q & ~(clr_i & arm_q));
            if (clr_i)
                arm_q <= 1'b0;
            else if (rd_i && flag_q)
                arm_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_q);

    // R4
    unarmed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !(clr_i && arm_q)) |=> (flag_q || !$past(flag_q)));

    // R3
    armed_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && arm_q && !set_i) |=> !flag_q);

    // R11
    no_arm_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && !arm_q) |=> !arm_q);

endmodule

// File: rtl/rxif_seq_guard.sv
module rxif_seq_guard
    import rxif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [LANE_N-1:0] old_en_i,
    input  logic [LANE_N-1:0] new_en_i,
    input  logic [LANE_N-1:0] fifo_rst_i,
    output logic              viol_o
);
    logic [LANE_N-1:0] prime_q;
    logic [LANE_N-1:0] rise;
    logic [LANE_N-1:0] bad;
    logic              viol_q;

    for (genvar g = 0; g < LANE_N; g++) begin : g_lane
        assign rise[g] = wr_i & new_en_i[g] & ~old_en_i[g];
        assign bad[g]  = rise[g] & ~(prime_q[g] | fifo_rst_i[g]);

        always_ff @(posedge clk) begin
            if (rst)
                prime_q[g] <= 1'b0;
            else if (rise[g])
                prime_q[g] <= 1'b0;
            else if (fifo_rst_i[g])
                prime_q[g] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            viol_q <= 1'b0;
        else if (|bad)
            viol_q <= 1'b1;
    end

    assign viol_o = viol_q;

    // R10
    viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        viol_q |=> viol_q);

    // R9
    clean_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!viol_q && !wr_i) |=> !viol_q);

endmodule

// File: rtl/rxif_irq_gen.sv
module rxif_irq_gen
    import rxif_pkg::*;
(
    input  logic [FLAG_N-1:0] flags_i,
    input  ctl_t              ctl_i,
    output irq_t              irq_o
);
    logic err_en;

    always_comb begin
        err_en     = any_rx_en(ctl_i);
        irq_o.rxd  = ctl_i.rie & (flags_i[FL_THR] | flags_i[FL_DRY]);
        irq_o.err  = err_en & flags_i[FL_ERR];
        irq_o.brk  = err_en & (flags_i[FL_BRK] | flags_i[FL_OVR]);
    end

endmodule

// File: rtl/rxif_ctrl.sv
module rxif_ctrl
    import rxif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_N-1:0] flag_set,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic [FLAG_N-1:0] stat_wdata,
    output logic [STAT_W-1:0] stat_rdata,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              tx_fifo_rst,
    input  logic              rx_fifo_rst,
    output logic              irq_rxd,
    output logic              irq_err,
    output logic              irq_brk
);
    ctl_t              ctl_q;
    ctl_t              ctl_new;
    logic [FLAG_N-1:0] flags;
    logic [FLAG_N-1:0] clr_req;
    logic              viol;
    irq_t              irq;
    logic [LANE_N-1:0] old_en;
    logic [LANE_N-1:0] new_en;
    logic [LANE_N-1:0] fifo_rst;

    assign ctl_new = ctl_t'(ctl_wdata);
    assign clr_req = {FLAG_N{stat_wr}} & ~stat_wdata;

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (ctl_wr)
            ctl_q <= ctl_new;
    end

    for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
        rxif_flag_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (flag_set[f]),
            .rd_i   (stat_rd),
            .clr_i  (clr_req[f]),
            .flag_o (flags[f])
        );
    end

    assign old_en[LN_TX]   = ctl_q.te;
    assign old_en[LN_RX]   = ctl_q.re;
    assign new_en[LN_TX]   = ctl_new.te;
    assign new_en[LN_RX]   = ctl_new.re;
    assign fifo_rst[LN_TX] = tx_fifo_rst;
    assign fifo_rst[LN_RX] = rx_fifo_rst;

    rxif_seq_guard u_guard (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (ctl_wr),
        .old_en_i   (old_en),
        .new_en_i   (new_en),
        .fifo_rst_i (fifo_rst),
        .viol_o     (viol)
    );

    rxif_irq_gen u_irq (
        .flags_i (flags),
        .ctl_i   (ctl_q),
        .irq_o   (irq)
    );

    assign stat_rdata = {viol, flags};
    assign irq_rxd    = irq.rxd;
    assign irq_err    = irq.err;
    assign irq_brk    = irq.brk;

    // R6
    rxd_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        irq_rxd |-> ctl_q.rie);

    // R7
    err_withdraw_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.rie && !ctl_q.reie) |-> (!irq_err && !irq_brk));

    // R8
    ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (ctl_q == $past(ctl_new)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (stat_rdata == '0 && !irq_rxd && !irq_err && !irq_brk));

endmodule

// File: tb/rxif_ctrl_test.sv
module rxif_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 25;

    // {req4, set5, rd, wr, wd5, cw, cd4, txr, rxr, exp_stat6, exp_irq3}
    localparam logic [31:0] VEC [NV] = '{
        {4'd8,  5'b00000,1'b0,1'b0,5'b00000,1'b1,4'b0011,1'b0,1'b0,6'b000000,3'b000}, // R8
        {4'd6,  5'b00001,1'b0,1'b0,5'b00000,1'b0,4'b0000,1'b0,1'b0,6'b000001,3'b100}, // R6
        {4'd4,  5'b00000,1'b0,1'b1,5'b00000,1'b0,4'b0000,1'b0,1'b0,6'b000001,3'b100}, // R4
        {4'd3,  5'b00000,1'b1,1'b0,5'b00000,1'b0,4'b0000,1'b0,1'b0,6'b000001,3'b100}, // R3
        {4'd3,  5'b00000,1'b0,1'b1,5'b11110,1'b0,4'b0000,1'b0,1'b0,6'b000000,3'b000}, // R3
        {4'd7,  5'b00100,1'b0,1'b0,5'b00000,1'b0,4'b0000,1'b0,1'b0,6'b000100,3'b010}, // R7
        {4'd7,  5'b01000,1'b0,1'b0,5'b00000,1'b0,4'b0000,1'b0,1'b0,6'b001100,3'b011}, // R7
        {4'd7,  5'b00000,1'b0,1'b0,5'b00000,1'b1,4'b0010,1'b0,1'b0,6'b001100,3'b011}, // R7
        {4'd7,  5'b00000,1'b0,1'b0,5'b00000,1'b1,4'b0000,1'b0,1'b0,6'b001100,3'b000}, // R7
        {4'd3,  5'b00000,1'b1,1'b0,5'b00000,1'b0,4'b0000,1'b0,1'b0,6'b001100,3'b000}, // R3
        {4'd5,  5'b00100,1'b0,1'b1,5'b10011,1'b0,4'b0000,1'b0,1'b0,6'b000100,3'b000}, // R5
        {4'd11, 5'b00000,1'b0,1'b1,5'b11011,1'b0,4'b0000,1'b0,1'b0,6'b000100,3'b000}, // R11
        {4'd3,  5'b00000,1'b1,1'b0,5'b00000,1'b0,4'b0000,1'b0,1'b0,6'b000100,3'b000}, // R3
        {4'd2,  5'b00010,1'b0,1'b0,5'b00000,1'b0,4'b0000,1'b0,1'b0,6'b000110,3'b000}, // R2
        {4'd11, 5'b00000,1'b0,1'b1,5'b11001,1'b0,4'b0000,1'b0,1'b0,6'b000010,3'b000}, // R11
        {4'd6,  5'b00000,1'b0,1'b0,5'b00000,1'b1,4'b0001,1'b0,1'b0,6'b000010,3'b100}, // R6
        {4'd7,  5'b10000,1'b0,1'b0,5'b00000,1'b0,4'b0000,1'b0,1'b0,6'b010010,3'b101}, // R7
        {4'd9,  5'b00000,1'b0,1'b0,5'b00000,1'b0,4'b0000,1'b0,1'b1,6'b010010,3'b101}, // R9
        {4'd9,  5'b00000,1'b0,1'b0,5'b00000,1'b1,4'b1001,1'b0,1'b0,6'b010010,3'b101}, // R9
        {4'd9,  5'b00000,1'b0,1'b0,5'b00000,1'b1,4'b1101,1'b0,1'b0,6'b110010,3'b101}, // R9
        {4'd10, 5'b00000,1'b0,1'b1,5'b00000,1'b0,4'b0000,1'b0,1'b0,6'b110010,3'b101}, // R10
        {4'd3,  5'b00000,1'b1,1'b0,5'b00000,1'b0,4'b0000,1'b0,1'b0,6'b110010,3'b101}, // R3
        {4'd10, 5'b00000,1'b0,1'b1,5'b00000,1'b0,4'b0000,1'b0,1'b0,6'b100000,3'b000}, // R10
        {4'd2,  5'b00001,1'b0,1'b0,5'b00000,1'b0,4'b0000,1'b0,1'b0,6'b100001,3'b100}, // R2
        {4'd4,  5'b00000,1'b0,1'b1,5'b11111,1'b0,4'b0000,1'b0,1'b0,6'b100001,3'b100}  // R4
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] flag_set = '0;
    logic       stat_rd = 1'b0;
    logic       stat_wr = 1'b0;
    logic [4:0] stat_wdata = '0;
    logic [5:0] stat_rdata;
    logic       ctl_wr = 1'b0;
    logic [3:0] ctl_wdata = '0;
    logic       tx_fifo_rst = 1'b0;
    logic       rx_fifo_rst = 1'b0;
    logic       irq_rxd, irq_err, irq_brk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxif_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .flag_set    (flag_set),
        .stat_rd     (stat_rd),
        .stat_wr     (stat_wr),
        .stat_wdata  (stat_wdata),
        .stat_rdata  (stat_rdata),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .tx_fifo_rst (tx_fifo_rst),
        .rx_fifo_rst (rx_fifo_rst),
        .irq_rxd     (irq_rxd),
        .irq_err     (irq_err),
        .irq_brk     (irq_brk)
    );

    task automatic check(input int req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic idle();
        flag_set = '0; stat_rd = 0; stat_wr = 0; stat_wdata = '0;
        ctl_wr = 0; ctl_wdata = '0; tx_fifo_rst = 0; rx_fifo_rst = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        flag_set = 5'b11111; // ignored during reset
        repeat (3) @(negedge clk);
        check(1, "status in reset", {2'b0, stat_rdata}, 8'h00); // R1
        check(1, "irqs in reset", {5'b0, irq_rxd, irq_err, irq_brk}, 8'h00);
        flag_set = '0;
        rst = 1'b0;
        @(negedge clk);
        check(1, "status after reset", {2'b0, stat_rdata}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            flag_set    = v[27:23];
            stat_rd     = v[22];
            stat_wr     = v[21];
            stat_wdata  = v[20:16];
            ctl_wr      = v[15];
            ctl_wdata   = v[14:11];
            tx_fifo_rst = v[10];
            rx_fifo_rst = v[9];
            @(negedge clk);
            check(int'(v[31:28]), $sformatf("vec%0d status", i),
                  {2'b0, stat_rdata}, {2'b0, v[8:3]});
            check(int'(v[31:28]), $sformatf("vec%0d irq", i),
                  {5'b0, irq_rxd, irq_err, irq_brk}, {5'b0, v[2:0]});
        end
        idle();

        // R10: only reset clears the fault bit
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(10, "fault cleared by reset", {2'b0, stat_rdata}, 8'h00);

        // R9: FIFO reset in the same cycle as the rising write counts
        ctl_wr = 1; ctl_wdata = 4'b0100; tx_fifo_rst = 1;
        @(negedge clk);
        idle();
        check(9, "tx rise with same-cycle reset", {2'b0, stat_rdata}, 8'h00);
        ctl_wr = 1; ctl_wdata = 4'b0000;
        @(negedge clk);
        idle();
        check(9, "tx drop", {2'b0, stat_rdata}, 8'h00);
        ctl_wr = 1; ctl_wdata = 4'b0100;
        @(negedge clk);
        idle();
        check(9, "tx rise with permission used", {2'b0, stat_rdata}, 8'h20);
        @(negedge clk);
        check(10, "fault held", {2'b0, stat_rdata}, 8'h20);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule